// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management register space of a 10/100 Ethernet PHY. It sits behind the register-index port of a serial management slave. It holds thirty-two 16-bit registers. Most of them are plain storage: a write lands on the clock edge and reads back unchanged from then on. Three indices are different. The link status word, the link-partner ability word and a speed/duplex diagnostic word are built afresh on every read. They are computed from a registered copy of the link input and from the local advertisement register (index 4). Reset loads the control word, the two identity words and the advertisement word with their defaults, and it forces the internal link flag to "up".

Read data is combinational from the read index. The port carries no stream, so there is no valid/ready pair. A write is accepted on every edge where the write strobe is high, and a read index may be presented on any cycle, so there is no back-pressure. The link input passes through a synchronous sampling stage of `LINK_STAGES` flops (default 1) before it reaches the computed words.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While reset is held and after reset, reads return 0x3100 at index 0, 0x0300 at index 2, 0xE400 at index 3 and 0x01E1 at index 4. Every other stored index reads 0x0000.
- R2: A write with the strobe high stores the data at the addressed index on that clock edge. A read of that index in any later cycle returns the data.
- R3: Writes to indices 1, 5 and 18 are accepted into storage, but the read values of those indices stay the computed ones.
- R4: Index 1 reads 0x0000 when the registered link flag is down. When the flag is up it reads 0x782C, which is bits 14, 13, 12, 11, 5, 3 and 2 set.
- R5: Index 5 reads bit 14 and bit 0 set, with bits 8:5 equal to bits 8:5 of the advertisement register and all other bits clear. This holds whatever the link state.
- R6: Index 18 reads 0x0000 when the link flag is down. When the flag is up, bit 10 is set if advertisement bit 7 (100 half) or bit 8 (100 full) is set. Bit 11 is set if advertisement bit 8 or bit 6 (10 full) is set. All other bits are clear.
- R7: With one sampling stage, a change on `link_i` is not seen by a read in the same cycle. It is seen from the cycle after the next clock edge.
- R8: A write to the advertisement register changes the read values of indices 5 and 18 from the next cycle on. Index 4 reads back the whole written word.
- R9: A cycle with the write strobe low changes no register, whatever index and data are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_i | input | 1 | Raw link indication, high means link up |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 16 | Data to store |
| rd_idx | input | 5 | Register index for the read |
| rd_data | output | 16 | Read data, combinational from `rd_idx` |

## Verification
An error in stored state shows up on `rd_data` in the first cycle that the faulty index is presented to the read port. Corrupted advertisement bits show up in three places: the index 4 read-back, the masked field at index 5 and the derived bits at index 18. A wrong link flag shows up only at indices 1 and 18, and one cycle after the input changes. The checks therefore read every computed index after each change of the advertisement word or the link input. They also repeat reads of untouched indices after writes elsewhere, so that a misdirected write is caught.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W = 16;

  // register indices whose behaviour is fixed
  localparam int IDX_CTRL    = 0;
  localparam int IDX_STATUS  = 1;
  localparam int IDX_ID_HI   = 2;
  localparam int IDX_ID_LO   = 3;
  localparam int IDX_ADV     = 4;
  localparam int IDX_PARTNER = 5;
  localparam int IDX_DIAG    = 18;

  // advertisement bit positions
  localparam int ADV_F_LO   = 5;
  localparam int ADV_F_HI   = 8;
  localparam int ADV_F_W    = ADV_F_HI - ADV_F_LO + 1;
  localparam int ADV_10FD   = 6;
  localparam int ADV_100HD  = 7;
  localparam int ADV_100FD  = 8;

  // computed word bit positions
  localparam int PARTNER_ACK = 14;
  localparam int PARTNER_SEL = 0;
  localparam int DIAG_SPEED  = 10;
  localparam int DIAG_DUPLEX = 11;

  localparam logic [REG_W-1:0] STATUS_UP_WORD = 16'h782C;

  function automatic logic [REG_W-1:0] reset_word(input int idx);
    case (idx)
      IDX_CTRL:  return 16'h3100;
      IDX_ID_HI: return 16'h0300;
      IDX_ID_LO: return 16'hE400;
      IDX_ADV:   return 16'h01E1;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  output logic link_o
);
  logic [STAGES-1:0] st;
  logic              armed;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '1;
        else        st <= link_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '1;
        else        st <= {st[STAGES-2:0], link_i};
      end
    end
  endgenerate

  assign link_o = st[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7: first stage holds the input seen at the previous edge
  p_link_sampled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (st[0] == $past(link_i)));
endmodule

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
#(
  parameter  int NUM_REGS = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_word,
  output logic [REG_W-1:0] adv_word
);
  logic [NUM_REGS-1:0][REG_W-1:0] words;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [REG_W-1:0] RST = reset_word(g);
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              q <= RST;
        else if (wr_en && wr_idx == IDX_W'(g))   q <= wr_data;
      end
      assign words[g] = q;
    end
  endgenerate

  assign rd_word  = words[rd_idx];
  assign adv_word = words[IDX_ADV];

  // R2: a strobed write is visible at its index after the edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rst_n) |=> (words[$past(wr_idx)] == $past(wr_data)));

  // R9: without a strobe the advertisement word holds
  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rst_n) |=> $stable(adv_word));
endmodule

// File: rtl/phy_live_regs.sv
module phy_live_regs
  import phy_mgmt_pkg::*;
(
  input  logic               link,
  input  logic [ADV_F_W-1:0] adv_field,
  output logic [REG_W-1:0]   status_word,
  output logic [REG_W-1:0]   partner_word,
  output logic [REG_W-1:0]   diag_word
);
  localparam int O10FD  = ADV_10FD  - ADV_F_LO;
  localparam int O100HD = ADV_100HD - ADV_F_LO;
  localparam int O100FD = ADV_100FD - ADV_F_LO;

  logic speed100, full_dup;

  assign speed100 = adv_field[O100HD] | adv_field[O100FD];
  assign full_dup = adv_field[O100FD] | adv_field[O10FD];

  always_comb begin
    status_word = link ? STATUS_UP_WORD : '0;

    partner_word = '0;
    partner_word[PARTNER_ACK]       = 1'b1;
    partner_word[PARTNER_SEL]       = 1'b1;
    partner_word[ADV_F_HI:ADV_F_LO] = adv_field;

    diag_word = '0;
    if (link) begin
      diag_word[DIAG_SPEED]  = speed100;
      diag_word[DIAG_DUPLEX] = full_dup;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter  int NUM_REGS    = 32,
  parameter  int LINK_STAGES = 1,
  localparam int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_i,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data
);
  logic             link_q;
  logic [REG_W-1:0] stored_word, adv_word;
  logic [REG_W-1:0] status_word, partner_word, diag_word;

  phy_link_sync #(.STAGES(LINK_STAGES)) i_link (
    .clk(clk), .rst_n(rst_n), .link_i(link_i), .link_o(link_q)
  );

  phy_reg_store #(.NUM_REGS(NUM_REGS)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_word(stored_word), .adv_word(adv_word)
  );

  phy_live_regs i_live (
    .link(link_q),
    .adv_field(adv_word[ADV_F_HI:ADV_F_LO]),
    .status_word(status_word),
    .partner_word(partner_word),
    .diag_word(diag_word)
  );

  always_comb begin
    case (int'(rd_idx))
      IDX_STATUS:  rd_data = status_word;
      IDX_PARTNER: rd_data = partner_word;
      IDX_DIAG:    rd_data = diag_word;
      default:     rd_data = stored_word;
    endcase
  end

  // R4: status reads zero while the link flag is down
  p_status_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) == IDX_STATUS && !link_q) |-> (rd_data == '0));

  // R5: partner word keeps its fixed bits and nothing outside the field
  p_partner_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) == IDX_PARTNER) |->
      (rd_data[PARTNER_ACK] && rd_data[PARTNER_SEL] && ((rd_data & ~16'h41E1) == '0)));

  // R6: a nonzero diagnostic word needs the link up
  p_diag_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) == IDX_DIAG && rd_data != '0) |-> link_q);

  // R8: an advertisement write is held whole
  p_adv_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rst_n && int'(wr_idx) == IDX_ADV) |=> (adv_word == $past(wr_data)));
endmodule

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_i = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int          q_idx[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  phy_mgmt_regs i_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .link_i(link_i),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      int          idx;
      logic [15:0] e;
      string       t;
      idx = q_idx.pop_front();
      e   = q_exp.pop_front();
      t   = q_tag.pop_front();
      n_run++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s idx %0d: got %h expected %h", t, idx, rd_data, e);
      end
    end
  end

  task automatic rd(input int idx, input logic [15:0] e, input string t);
    rd_idx = 5'(idx);
    q_idx.push_back(idx); q_exp.push_back(e); q_tag.push_back(t);
    @(posedge clk); #1;
  endtask

  task automatic rd_link(input int idx, input logic [15:0] e, input logic l, input string t);
    link_i = l;
    rd(idx, e, t);
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle_bus(input int idx, input logic [15:0] d);
    wr_en = 1'b0; wr_idx = 5'(idx); wr_data = d;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    do_reset();
    // R1 defaults
    rd(0, 16'h3100, "R1");
    rd(2, 16'h0300, "R1");
    rd(3, 16'hE400, "R1");
    rd(4, 16'h01E1, "R1");
    rd(6, 16'h0000, "R1");
    rd(31, 16'h0000, "R1");
    // computed words with default advertisement
    rd(1, 16'h782C, "R4");
    rd(5, 16'h41E1, "R5");
    rd(18, 16'h0C00, "R6");
    // R2 plain storage
    wr(9, 16'hA5C3);
    rd(9, 16'hA5C3, "R2");
    wr(31, 16'h1234);
    rd(31, 16'h1234, "R2");
    rd(9, 16'hA5C3, "R2");
    wr(0, 16'hFFFF);
    rd(0, 16'hFFFF, "R2");
    // R9 strobe low
    idle_bus(9, 16'h0F0F);
    idle_bus(4, 16'h0000);
    rd(9, 16'hA5C3, "R9");
    rd(4, 16'h01E1, "R9");
    // R3 writes to computed indices
    wr(1, 16'h0000);
    rd(1, 16'h782C, "R3");
    wr(5, 16'h0000);
    rd(5, 16'h41E1, "R3");
    wr(18, 16'hFFFF);
    rd(18, 16'h0C00, "R3");
    // R8 advertisement patterns
    wr(4, 16'h0080);
    rd(5, 16'h4081, "R8");
    rd(18, 16'h0400, "R8");
    wr(4, 16'h0040);
    rd(5, 16'h4041, "R8");
    rd(18, 16'h0800, "R8");
    wr(4, 16'h0020);
    rd(5, 16'h4021, "R8");
    rd(18, 16'h0000, "R8");
    wr(4, 16'h0100);
    rd(5, 16'h4101, "R8");
    rd(18, 16'h0C00, "R8");
    wr(4, 16'hFE1F);
    rd(4, 16'hFE1F, "R8");
    rd(5, 16'h4001, "R5");
    rd(18, 16'h0000, "R6");
    wr(4, 16'h01E1);
    // R7 link sampling
    rd_link(1, 16'h782C, 1'b0, "R7");
    rd(1, 16'h0000, "R4");
    rd(18, 16'h0000, "R6");
    rd(5, 16'h41E1, "R5");
    rd_link(18, 16'h0000, 1'b1, "R7");
    rd(18, 16'h0C00, "R7");
    rd(1, 16'h782C, "R7");
    // reset again restores defaults
    do_reset();
    rd(9, 16'h0000, "R1");
    rd(0, 16'h3100, "R1");
    rd(4, 16'h01E1, "R1");
    @(posedge clk); #1;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule